// File: doc/BRIEF.md
# GF(2^163) Hybrid Karatsuba Field Multiplier

This block multiplies two elements of the binary extension field GF(2^163). It is meant for the scalar-multiplication datapath of an elliptic-curve engine. Elements use polynomial basis: bit i of a 163-bit word is the coefficient of x^i. Coefficients are added with XOR, so no carries ever propagate.

The raw product is built by recursive Karatsuba splitting. The 163-bit operands split into halves of 82 bits, and each half splits again into 41-bit pieces. At that size the splitting stops and a plain AND/XOR partial-product array multiplies the pieces. The 325-bit carry-less product is registered. A fixed XOR network then folds it back below degree 163 using the field polynomial x^163 + x^7 + x^6 + x^3 + 1, and the folded result is registered at the output.

A new operand pair can be presented on every clock. Each result appears exactly two cycles after its pair, together with a valid flag. There is no backpressure.

Top module: `gf163_mul`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, out_valid is 0 and out_p is all zeros.
- R2: out_p equals in_a times in_b modulo x^163 + x^7 + x^6 + x^3 + 1, where bit i of every 163-bit word is the coefficient of x^i.
- R3: A pair sampled with in_valid high at clock edge k gives out_valid high after edge k+2. out_valid is low on every cycle whose pair, two edges earlier, had in_valid low.
- R4: Pairs presented on consecutive cycles give results on consecutive cycles, in the same order, each one correct.
- R5: If either operand of a valid pair is zero, the corresponding out_p is zero.
- R6: If in_b of a valid pair equals 1, the corresponding out_p equals that pair's in_a.
- R7: While out_valid is low, out_p keeps its previous value, whatever the inputs do.
- R8: The highest-degree case is reduced fully. For x^162 times x^162 the raw product is x^324, which needs both folding passes, and out_p still equals the field product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 163 | First field operand |
| in_b | input | 163 | Second field operand |
| out_valid | output | 1 | out_p carries a new product |
| out_p | output | 163 | Reduced field product |

## Verification
The assertions check on every cycle that the valid flag trails in_valid by exactly two edges, that out_p stays still whenever no result is delivered, and that the two algebraic identities hold: a zero operand gives zero, and a unit in_b passes in_a through. These properties cannot show that a general product is correct, nor that both folding passes act on the highest-degree terms. Only the bench's scenarios can show those points, by comparing random, back-to-back and extreme-degree results against a bit-serial shift-and-reduce model.

// File: rtl/gf163_pkg.sv
package gf163_pkg;
    localparam int M      = 163;
    localparam int CUTOFF = 41;
    localparam int RAW_W  = 2 * M - 1;

    typedef struct packed {
        logic             v1;
        logic [RAW_W-1:0] raw;
        logic             v2;
        logic [M-1:0]     res;
    } pipe_t;
endpackage

// File: rtl/gf_school_mul.sv
module gf_school_mul #(
    parameter int W = 41
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) p = p ^ ((2*W-1)'(a) << i);
        end
    end
endmodule

// File: rtl/gf_kara_mul.sv
module gf_kara_mul #(
    parameter int W      = 163,
    parameter int CUTOFF = 41
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    generate
        if (W <= CUTOFF) begin : g_leaf
            gf_school_mul #(.W(W)) u_leaf (.a(a), .b(b), .p(p));
        end else begin : g_split
            localparam int H = (W + 1) / 2;
            localparam int L = W - H;

            logic [H-1:0]   a_lo, a_hi, b_lo, b_hi, a_sum, b_sum;
            logic [2*H-2:0] p_lo, p_hi, p_mid, mid;

            always_comb begin
                a_lo = a[H-1:0];
                b_lo = b[H-1:0];
                a_hi = '0;
                b_hi = '0;
                a_hi[L-1:0] = a[W-1:H];
                b_hi[L-1:0] = b[W-1:H];
                a_sum = a_lo ^ a_hi;
                b_sum = b_lo ^ b_hi;
            end

            gf_kara_mul #(.W(H), .CUTOFF(CUTOFF)) u_lo  (.a(a_lo),  .b(b_lo),  .p(p_lo));
            gf_kara_mul #(.W(H), .CUTOFF(CUTOFF)) u_hi  (.a(a_hi),  .b(b_hi),  .p(p_hi));
            gf_kara_mul #(.W(H), .CUTOFF(CUTOFF)) u_mid (.a(a_sum), .b(b_sum), .p(p_mid));

            always_comb begin
                mid = p_mid ^ p_lo ^ p_hi;
                p = (2*W-1)'(p_lo)
                  ^ (2*W-1)'({mid, {H{1'b0}}})
                  ^ (2*W-1)'({p_hi, {(2*H){1'b0}}});
            end
        end
    endgenerate
endmodule

// File: rtl/gf163_reduce.sv
module gf163_reduce
    import gf163_pkg::*;
(
    input  logic [RAW_W-1:0] c,
    output logic [M-1:0]     r
);
    localparam int HI_W = RAW_W - M;
    localparam int T_W  = M + 6;
    localparam int H2_W = T_W - M;

    logic [HI_W-1:0] hi;
    logic [T_W-1:0]  t;
    logic [H2_W-1:0] h2;

    always_comb begin
        hi = c[RAW_W-1:M];
        t  = T_W'(c[M-1:0])
           ^ T_W'(hi)
           ^ (T_W'(hi) << 3)
           ^ (T_W'(hi) << 6)
           ^ (T_W'(hi) << 7);
        h2 = t[T_W-1:M];
        r  = t[M-1:0]
           ^ M'(h2)
           ^ (M'(h2) << 3)
           ^ (M'(h2) << 6)
           ^ (M'(h2) << 7);
    end
endmodule

// File: rtl/gf163_mul.sv
module gf163_mul
    import gf163_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [162:0] in_a,
    input  logic [162:0] in_b,
    output logic         out_valid,
    output logic [162:0] out_p
);
    pipe_t            st_d, st_q;
    logic [RAW_W-1:0] raw_w;
    logic [M-1:0]     red_w;

    gf_kara_mul #(.W(M), .CUTOFF(CUTOFF)) u_mul (.a(in_a), .b(in_b), .p(raw_w));
    gf163_reduce u_red (.c(st_q.raw), .r(red_w));

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) st_d.raw = raw_w;
        st_d.v2 = st_q.v1;
        if (st_q.v1) st_d.res = red_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign out_p     = st_q.res;
endmodule

// File: rtl/gf163_mul_chk.sv
module gf163_mul_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [162:0] in_a,
    input logic [162:0] in_b,
    input logic         out_valid,
    input logic [162:0] out_p
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cyc <= 2'd0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && $past(in_valid && (in_a == '0 || in_b == '0), 2)) |-> (out_p == '0));

    a_r6_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && $past(in_valid && in_b == 163'd1, 2)) |-> (out_p == $past(in_a, 2)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && !out_valid) |-> $stable(out_p));
endmodule

bind gf163_mul gf163_mul_chk u_chk (.*);

// File: tb/gf163_mul_tb.sv
module gf163_mul_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  W = 163;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_valid = 0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_p;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gf163_mul u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
                     .in_b(in_b), .out_valid(out_valid), .out_p(out_p));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        for (int i = W-1; i >= 0; i--) begin
            logic top = r[W-1];
            r = r << 1;
            if (top) r = r ^ W'(8'hC9);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd();
        return W'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 0;
        chk("R3 early", W'(out_valid), W'(0));
        @(negedge clk);
        chk("R3 valid", W'(out_valid), W'(1));
        chk(req, out_p, ref_mul(a, b));
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", W'(out_valid), W'(0));
        chk("R1 data in reset", out_p, '0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid after", W'(out_valid), W'(0));
        chk("R1 data after", out_p, '0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 10; i++) run_one("R2 random", rnd(), rnd());
        run_one("R2 all ones", '1, '1);
        run_one("R2 x times x", W'(2), W'(2));
    endtask

    task automatic t_zero();
        run_one("R5 zero b", rnd(), '0);
        run_one("R5 zero a", '0, rnd());
    endtask

    task automatic t_unit();
        logic [W-1:0] v = rnd();
        run_one("R6 unit b", v, W'(1));
        chk("R6 passthrough", out_p, v);
        run_one("R6 unit a", W'(1), v);
        chk("R6 passthrough a", out_p, v);
    endtask

    task automatic t_top_degree();
        logic [W-1:0] x162 = '0;
        x162[W-1] = 1'b1;
        run_one("R8 x162 squared", x162, x162);
        run_one("R8 full by x162", '1, x162);
    endtask

    task automatic t_stream();
        logic [W-1:0] exp_q [8];
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R4 stream valid", W'(out_valid), W'(1));
                chk("R4 stream data", out_p, exp_q[i-2]);
            end
            if (i < 8) begin
                logic [W-1:0] a = rnd();
                logic [W-1:0] b = rnd();
                in_valid = 1; in_a = a; in_b = b;
                exp_q[i] = ref_mul(a, b);
            end else begin
                in_valid = 0;
            end
        end
    endtask

    task automatic t_hold();
        logic [W-1:0] a = rnd();
        logic [W-1:0] b = rnd();
        logic [W-1:0] last;
        run_one("R7 setup", a, b);
        last = ref_mul(a, b);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_a = rnd(); in_b = rnd();
            chk("R7 idle valid", W'(out_valid), W'(0));
            chk("R7 held data", out_p, last);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_random();
        t_zero();
        t_unit();
        t_top_degree();
        t_stream();
        t_hold();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule